// File: doc/BRIEF.md
# Byte-Stuffing Stream Packet Framer

This block turns a byte-wide AXI4-Stream packet into a framed byte stream for a serial link, in the spirit of SLIP/PPP serial encoding but with three reserved codes instead of one. Each packet leaves the block as a start marker, then the payload, then an end marker. Any payload byte that equals one of the three reserved codes is replaced by a two-byte escape pair. This keeps the end marker unambiguous, so a receiver can raise TLAST whenever it sees that marker.

The output expands by a variable amount. The block therefore drops its input ready while it emits a byte that does not consume input: the start marker, the escape prefix and the end marker. Output backpressure passes straight to the input. When both sides are ready, ordinary payload bytes flow through at one per cycle.

Top module: `stuff_framer`

## Requirements
- R1: After reset, while no input byte is offered, m_tvalid and s_tready are both 0.
- R2: Before the first payload byte of each packet the block emits the start code 0x7E, and s_tready is 0 while that byte is on the output.
- R3: A payload byte that is not 0x7E, 0x7F or 0x7D appears on the output unchanged and in order. With m_tready held at 1 and the source offering bytes back to back, the output has no idle cycle between a packet's start code and its end code.
- R4: A payload byte equal to 0x7E, 0x7F or 0x7D leaves as two bytes: the escape code 0x7D, then the byte XOR 0x20. s_tready is 0 while the escape code is on the output.
- R5: After the payload byte that carries s_tlast, the block emits the end code 0x7F with m_tlast = 1, and s_tready is 0 while it does so. m_tlast is 0 on every other output byte.
- R6: While m_tvalid is 1 and m_tready is 0, the output byte, m_tvalid and m_tlast hold their values into the next cycle.
- R7: Back-to-back packets each get their own start and end codes. Under random backpressure on both sides, no byte is lost or duplicated.
- R8: The value 0x7F never appears on the output except as the end code with m_tlast = 1.
- R9: A one-byte packet is framed as start code, that byte (escaped if reserved), end code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted this cycle when high with s_tvalid |
| s_tdata | input | DATA_W | Input payload byte |
| s_tlast | input | 1 | Marks the final payload byte of a packet |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | DATA_W | Framed output byte |
| m_tlast | output | 1 | High only on the end code |

## Verification
The assertions on output hold and on the byte after an escape prefix assume that the source follows the stream rule. Once s_tvalid is raised, s_tdata and s_tlast stay fixed until the byte is accepted, because the block presents a held input byte combinationally while it is stalled. The bench's source changes its signals only just after an accepting clock edge, and idle gaps are inserted only between accepted bytes, so this assumption is never broken. The sink may drop m_tready at any cycle, and the hold property is written for exactly that case.

// File: rtl/stuff_framer_pkg.sv
package stuff_framer_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam logic [DEF_DATA_W-1:0] DEF_SOF  = 8'h7E;
  localparam logic [DEF_DATA_W-1:0] DEF_EOF  = 8'h7F;
  localparam logic [DEF_DATA_W-1:0] DEF_ESC  = 8'h7D;
  localparam logic [DEF_DATA_W-1:0] DEF_FLIP = 8'h20;

  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,  // waiting to send the start code
    ST_BODY = 2'd1,  // payload, or escape prefix of a reserved byte
    ST_ESC  = 2'd2,  // flipped second half of an escape pair
    ST_TAIL = 2'd3   // end code
  } frm_state_e;
endpackage

// File: rtl/frm_classify.sv
module frm_classify #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] SOF_CODE = 8'h7E,
  parameter logic [DATA_W-1:0] EOF_CODE = 8'h7F,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h7D
) (
  input  logic [DATA_W-1:0] data,
  output logic              hit
);
  localparam int unsigned NUM_CODES = 3;
  localparam logic [NUM_CODES*DATA_W-1:0] CODE_VEC = {ESC_CODE, EOF_CODE, SOF_CODE};

  logic [NUM_CODES-1:0] match;

  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_cmp
    assign match[gi] = (data == CODE_VEC[gi*DATA_W +: DATA_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/frm_fsm.sv
module frm_fsm
  import stuff_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       hit,
  input  logic       out_ready,
  output frm_state_e state
);
  frm_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_HEAD: if (in_valid && out_ready) state_d = ST_BODY;
      ST_BODY: begin
        if (in_valid && out_ready) begin
          if (hit)          state_d = ST_ESC;
          else if (in_last) state_d = ST_TAIL;
        end
      end
      ST_ESC:  if (in_valid && out_ready) state_d = in_last ? ST_TAIL : ST_BODY;
      ST_TAIL: if (out_ready) state_d = ST_HEAD;
      default: state_d = ST_HEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_HEAD;
    else        state <= state_d;
  end
endmodule

// File: rtl/frm_outmux.sv
module frm_outmux
  import stuff_framer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] SOF_CODE  = 8'h7E,
  parameter logic [DATA_W-1:0] EOF_CODE  = 8'h7F,
  parameter logic [DATA_W-1:0] ESC_CODE  = 8'h7D,
  parameter logic [DATA_W-1:0] FLIP_MASK = 8'h20
) (
  input  frm_state_e        state,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              hit,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  function automatic logic [DATA_W-1:0] flip_byte(input logic [DATA_W-1:0] d);
    return d ^ FLIP_MASK;
  endfunction

  always_comb begin
    out_valid = in_valid;
    out_data  = in_data;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    unique case (state)
      ST_HEAD: out_data = SOF_CODE;
      ST_BODY: begin
        out_data = hit ? ESC_CODE : in_data;
        in_ready = !hit && out_ready;
      end
      ST_ESC: begin
        out_data = flip_byte(in_data);
        in_ready = out_ready;
      end
      ST_TAIL: begin
        out_valid = 1'b1;
        out_data  = EOF_CODE;
        out_last  = 1'b1;
      end
      default: out_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/stuff_framer.sv
module stuff_framer
  import stuff_framer_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [DATA_W-1:0] SOF_CODE  = DEF_SOF,
  parameter logic [DATA_W-1:0] EOF_CODE  = DEF_EOF,
  parameter logic [DATA_W-1:0] ESC_CODE  = DEF_ESC,
  parameter logic [DATA_W-1:0] FLIP_MASK = DEF_FLIP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast
);
  frm_state_e w_state;
  logic       w_hit;
  logic       w_take;   // input byte accepted
  logic       w_emit;   // output byte delivered

  frm_classify #(
    .DATA_W(DATA_W), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE), .ESC_CODE(ESC_CODE)
  ) u_classify (
    .data(s_tdata),
    .hit (w_hit)
  );

  frm_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_tvalid),
    .in_last  (s_tlast),
    .hit      (w_hit),
    .out_ready(m_tready),
    .state    (w_state)
  );

  frm_outmux #(
    .DATA_W(DATA_W), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE),
    .ESC_CODE(ESC_CODE), .FLIP_MASK(FLIP_MASK)
  ) u_outmux (
    .state    (w_state),
    .in_valid (s_tvalid),
    .in_data  (s_tdata),
    .hit      (w_hit),
    .out_ready(m_tready),
    .in_ready (s_tready),
    .out_valid(m_tvalid),
    .out_data (m_tdata),
    .out_last (m_tlast)
  );

  assign w_take = s_tvalid && s_tready;
  assign w_emit = m_tvalid && m_tready;
endmodule

// File: rtl/stuff_framer_chk.sv
module stuff_framer_chk
  import stuff_framer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] SOF_CODE = 8'h7E,
  parameter logic [DATA_W-1:0] EOF_CODE = 8'h7F,
  parameter logic [DATA_W-1:0] ESC_CODE = 8'h7D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tlast,
  input frm_state_e        w_state,
  input logic              w_take,
  input logic              w_emit
);
  function automatic logic reserved(input logic [DATA_W-1:0] d);
    return (d == SOF_CODE) || (d == EOF_CODE) || (d == ESC_CODE);
  endfunction

  assert_head_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (w_state == ST_HEAD && !s_tvalid) |-> (!m_tvalid && !s_tready));

  assert_sof_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tdata == SOF_CODE) |-> !s_tready);

  assert_take_with_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_take |-> w_emit);

  assert_esc_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tdata == ESC_CODE) |-> !s_tready);

  assert_esc_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_emit && m_tdata == ESC_CODE) |=> (m_tvalid && !reserved(m_tdata)));

  assert_last_is_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tlast) |-> (m_tdata == EOF_CODE && !s_tready));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_end_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tdata == EOF_CODE) |-> m_tlast);
endmodule

bind stuff_framer stuff_framer_chk #(
  .DATA_W(DATA_W), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE), .ESC_CODE(ESC_CODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_tvalid(s_tvalid),
  .s_tready(s_tready),
  .m_tvalid(m_tvalid),
  .m_tready(m_tready),
  .m_tdata (m_tdata),
  .m_tlast (m_tlast),
  .w_state (w_state),
  .w_take  (w_take),
  .w_emit  (w_emit)
);

// File: tb/stuff_framer_tb.sv
`timescale 1ns/1ps
module stuff_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_tvalid = 1'b0;
  logic       s_tready;
  logic [7:0] s_tdata = 8'h00;
  logic       s_tlast = 1'b0;
  logic       m_tvalid;
  logic       m_tready = 1'b1;
  logic [7:0] m_tdata;
  logic       m_tlast;

  always #2.5 clk = ~clk;

  stuff_framer u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  typedef struct {
    logic [7:0] d;
    bit         last;
    bit         ctrl;
    string      req;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] pkt_b[0:15];
  int         n_checks = 0;
  int         n_fails  = 0;
  bit         running  = 0;
  bit         gapless  = 0;
  bit         rand_rdy = 0;
  bit         gap_en   = 0;
  bit         done     = 0;
  bit         frame_open = 0;
  bit         hold_pend  = 0;
  logic [7:0] hold_d;
  bit         hold_l;
  string      tag = "";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s%s act=0x%0h exp=0x%0h t=%0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic push_exp(input logic [7:0] d, input bit last, input bit ctrl, input string req);
    exp_t e;
    e.d = d; e.last = last; e.ctrl = ctrl; e.req = req;
    exp_q.push_back(e);
  endtask

  // reference framing, written from the requirements
  task automatic frame_ref(input int n);
    string r_body;
    r_body = (n == 1) ? "R9" : "R3";
    push_exp(8'h7E, 0, 1, "R2");
    for (int i = 0; i < n; i++) begin
      if (pkt_b[i] == 8'h7E || pkt_b[i] == 8'h7F || pkt_b[i] == 8'h7D) begin
        push_exp(8'h7D, 0, 1, "R4");
        push_exp(pkt_b[i] ^ 8'h20, 0, 0, "R4");
      end else begin
        push_exp(pkt_b[i], 0, 0, r_body);
      end
    end
    push_exp(8'h7F, 1, 1, "R5");
  endtask

  task automatic send_pkt(input int n);
    frame_ref(n);
    for (int i = 0; i < n; i++) begin
      if (gap_en) begin
        s_tvalid = 1'b0;
        repeat ($urandom % 3) begin @(posedge clk); #1; end
      end
      s_tvalid = 1'b1;
      s_tdata  = pkt_b[i];
      s_tlast  = (i == n - 1);
      forever begin
        @(negedge clk);
        if (s_tready) break;
      end
      @(posedge clk); #1;
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  // sink readiness, changed only just after a rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      m_tready = rand_rdy ? (($urandom % 100) < 65) : 1'b1;
    end
  end

  // monitor: compares against the reference queue every cycle
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (m_tvalid && m_tdata == 8'h7F)
        check(m_tlast == 1'b1, "R8", m_tlast, 1);
      if (hold_pend)
        check(m_tvalid && m_tdata == hold_d && m_tlast == hold_l, "R6",
              {m_tvalid, m_tlast, m_tdata}, {1'b1, hold_l, hold_d});
      hold_pend = m_tvalid && !m_tready;
      hold_d    = m_tdata;
      hold_l    = m_tlast;
      if (gapless && frame_open)
        check(m_tvalid == 1'b1, "R3", m_tvalid, 1);
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", m_tdata, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(m_tdata == e.d && m_tlast == e.last, e.req, {m_tlast, m_tdata}, {e.last, e.d});
          if (e.ctrl)
            check(s_tready == 1'b0, e.req, s_tready, 0);
          if (e.ctrl && e.d == 8'h7E) frame_open = 1;
          if (e.last) frame_open = 0;
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R7 watchdog expired act=%0d exp=0 pending", exp_q.size());
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle after reset
    repeat (2) begin
      @(negedge clk);
      check(m_tvalid == 1'b0, "R1", m_tvalid, 0);
      check(s_tready == 1'b0, "R1", s_tready, 0);
    end
    @(posedge clk); #1;
    running = 1;

    // directed, no backpressure, back-to-back bytes
    gapless = 1;
    tag = "";
    pkt_b[0] = 8'h01; pkt_b[1] = 8'h02; pkt_b[2] = 8'hA5; pkt_b[3] = 8'h7C;
    send_pkt(4);
    pkt_b[0] = 8'h55;
    send_pkt(1);                       // R9 plain single byte
    pkt_b[0] = 8'h7F;
    send_pkt(1);                       // R9 reserved single byte
    pkt_b[0] = 8'h7E; pkt_b[1] = 8'h10; pkt_b[2] = 8'h7F; pkt_b[3] = 8'h7D; pkt_b[4] = 8'h5E;
    send_pkt(5);
    repeat (4) @(posedge clk); #1;
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);

    // random traffic with backpressure on both sides
    gapless  = 0;
    rand_rdy = 1;
    gap_en   = 1;
    tag = "/R7";
    for (int p = 0; p < 60; p++) begin
      int n;
      n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++)
        pkt_b[i] = (($urandom % 10) < 3) ? (8'h7C + 8'($urandom % 4)) : 8'($urandom);
      send_pkt(n);
    end
    repeat (200) begin
      if (exp_q.size() == 0) break;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    check(m_tvalid == 1'b0, "R1", m_tvalid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule